// File: doc/BRIEF.md
# Timer/Event Counter with Reload

This block is an 8-bit up-counter with three working modes. In timer mode it counts ticks of a divided system clock. In event mode it counts edges on an external input. In pulse-width mode it counts divided-clock ticks only while the external input sits at a chosen level. A reload register gives the value the counter starts from after each wrap. Every wrap past the all-ones value gives a single-cycle interrupt pulse.

Software sees two registers through a simple strobe-and-select interface. The control register holds the mode, the run enable, the edge choice and the divider select. The count register returns the live count on reads, and a write to it sets the reload value. A write to the reload register behaves differently depending on whether the counter is running, and the same edge bit means different things in event mode and in pulse-width mode.

The external input is synchronised through two flops before its edges are detected. In event mode, each level of the input must therefore last at least two system clocks.

Top module: `evtimer_top`

## Requirements
- R1: On each qualifying tick the count rises by one. The tick that finds the count at 8'hFF loads the reload value instead. In the cycle after that edge, `irq` is high for exactly one cycle.
- R2: A write to address 1 while the counter is stopped (run bit 0, or mode 00) stores the data as the reload value and also loads it into the count at the same clock edge.
- R3: A write to address 1 while the counter is running changes only the reload value. The count keeps its sequence, and the new value first appears in the count at the next wrap.
- R4: Control bits 7:6 select the mode: 00 idle, 01 event counting, 10 timer, 11 pulse-width measurement. In mode 00 the count never changes by itself, even with the run bit set.
- R5: Control bit 4 is the run enable. While it is 0 the count holds its value.
- R6: In timer mode, control bits 2:0 (value N) make the count advance once every 2^N clocks. The first advance comes exactly 2^N clocks after the edge at which a write sets the run bit from 0 to 1.
- R7: In event mode, control bit 3 picks the counted edge of `ext_in`: 0 counts rising edges, 1 counts falling edges. The divider select has no effect. A change on `ext_in` reaches the count at the third clock edge after it.
- R8: In pulse-width mode with control bit 3 = 1, divided ticks are counted from a rising edge of `ext_in` to the following falling edge. With bit 3 = 0, they are counted from a falling edge to the following rising edge. For N = 0 the result equals the pulse width in clocks.
- R9: The closing edge of a measurement clears the run bit in hardware. The count then holds, and later pulses are ignored until software sets the run bit again.
- R10: Reads with `rd_sel` = 0 return the control register with bit 5 always 0. Reads with `rd_sel` = 1 return the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 control, 1 reload/count |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 live count |
| rd_data | output | 8 | Read data, combinational from `rd_sel` |
| ext_in | input | 1 | External event or gate input, asynchronous |
| irq | output | 1 | Single-cycle pulse on counter wrap |

## Verification
A wrong divider phase or a wrong arm clear moves the first increment away from the 2^N-th clock. That shows on the count port within one divided period after enabling. A wrong edge polarity or a broken synchroniser stage changes either the number of events counted or the three-edge latency, and this is visible on the first edge driven. A reload or gating fault shows as a wrong count at the wrap cycle or at the end of a measurement. A run bit that hardware fails to clear shows on the next control read, and a later pulse then adds to a count that should hold.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmode_e;

  // control register layout, most significant field first
  typedef struct packed {
    tmode_e     mode;
    logic       spare;
    logic       run;
    logic       edge_sel;
    logic [2:0] ps_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // bus value to control fields, spare bit forced low
  function automatic ctrl_t ctrl_from_bus(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c = ctrl_t'(d);
    c.spare = 1'b0;
    return c;
  endfunction

  // select one of the two detected edges by a polarity bit
  function automatic logic pick_edge(input logic sel, input logic rise, input logic fall);
    return sel ? fall : rise;
  endfunction

endpackage

// File: rtl/evtimer_edge.sv
module evtimer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise =  chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] &  last;

endmodule

// File: rtl/evtimer_prescale.sv
module evtimer_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  // low sel bits set: the divider phase that ends a period
  function automatic logic [DIV_W-1:0] span_mask(input logic [SEL_W-1:0] s);
    return ~({DIV_W{1'b1}} << s);
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (arm) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end

  assign mask = span_mask(sel);
  assign tick = ((div_q & mask) == mask);

  // R6: after a restart no tick arrives at once unless the ratio is 1:1
  p_arm_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && sel != '0) |=> !tick);

endmodule

// File: rtl/evtimer_core.sv
module evtimer_core
  import evtimer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmode_e           mode,
  input  logic             run,
  input  logic             edge_sel,
  input  logic             ps_tick,
  input  logic             ext_rise,
  input  logic             ext_fall,
  input  logic             pre_wr,
  input  logic [CNT_W-1:0] pre_data,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             meas_done
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] preload;
  logic             gate_on;
  logic             running;
  logic             start_edge;
  logic             stop_edge;
  logic             event_edge;
  logic             tick;
  logic             overflow;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld);
    return (cur == TOP) ? rld : cur + 1'b1;
  endfunction

  assign running    = run && (mode != MODE_IDLE);
  assign event_edge = pick_edge(edge_sel, ext_rise, ext_fall);
  assign start_edge = pick_edge(!edge_sel, ext_rise, ext_fall);
  assign stop_edge  = pick_edge(edge_sel, ext_rise, ext_fall);

  always_comb begin
    unique case (mode)
      MODE_TIMER: tick = run && ps_tick;
      MODE_EVENT: tick = run && event_edge;
      MODE_PULSE: tick = run && gate_on && ps_tick;
      default:    tick = 1'b0;
    endcase
  end

  assign overflow  = tick && (count == TOP);
  assign meas_done = run && (mode == MODE_PULSE) && gate_on && stop_edge;

  // measurement window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               gate_on <= 1'b0;
    else if (!run || mode != MODE_PULSE)      gate_on <= 1'b0;
    else if (!gate_on && start_edge)          gate_on <= 1'b1;
    else if (gate_on && stop_edge)            gate_on <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preload <= '0;
    else if (pre_wr) preload <= pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (pre_wr && !running)  count <= pre_data;
    else if (tick)                count <= next_count(count, preload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= overflow;
  end

  // R1: a wrap reloads and raises the interrupt
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (irq && count == $past(preload)));

  // R2: a stopped counter takes written data at once
  p_stopped_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wr && !running) |=> (count == $past(pre_data)));

  // R3: a running counter ignores the write until the next wrap
  p_running_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wr && running && !tick) |=> (count == $past(count)));

  // R4: idle mode never moves the count
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE && !pre_wr) |=> $stable(count));

  // R5: run bit low holds the count
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pre_wr) |=> $stable(count));

  // R8: a window exists only in pulse-width mode
  p_gate_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PULSE) |=> !gate_on);

endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
  import evtimer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       ext_in,
  output logic       irq
);

  localparam int CNT_W = CTRL_W;
  localparam int SEL_W = 3;

  ctrl_t            ctrl;
  logic             ctrl_wr;
  logic             pre_wr;
  logic             arm;
  logic             ps_tick;
  logic             ext_rise;
  logic             ext_fall;
  logic             meas_done;
  logic [CNT_W-1:0] count;

  assign ctrl_wr = wr_en && !wr_sel;
  assign pre_wr  = wr_en &&  wr_sel;
  assign arm     = ctrl_wr && wr_data[4] && !ctrl.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl <= '0;
    else if (ctrl_wr)   ctrl <= ctrl_from_bus(wr_data);
    else if (meas_done) ctrl.run <= 1'b0;
  end

  evtimer_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_in),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  evtimer_prescale #(.SEL_W(SEL_W)) pres_i (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (arm),
    .sel  (ctrl.ps_sel),
    .tick (ps_tick)
  );

  evtimer_core #(.CNT_W(CNT_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ctrl.mode),
    .run      (ctrl.run),
    .edge_sel (ctrl.edge_sel),
    .ps_tick  (ps_tick),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .pre_wr   (pre_wr),
    .pre_data (wr_data),
    .count    (count),
    .irq      (irq),
    .meas_done(meas_done)
  );

  assign rd_data = rd_sel ? count : ctrl;

  // R9: the closing edge of a measurement drops the run bit
  p_done_clears_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !ctrl_wr) |=> !ctrl.run);

  // R10: spare control bit reads as zero
  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel) |-> (rd_data[5] == 1'b0));

endmodule

// File: tb/evtimer_top_tb.sv
module evtimer_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evtimer_top dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .rd_sel (rd_sel),
    .rd_data(rd_data),
    .ext_in (ext_in),
    .irq    (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  // one pulse-width measurement: polarity te, divider n, width w clocks
  task automatic measure(input logic te, input int n, input int w);
    logic [7:0] v;
    logic [7:0] base;
    base = 8'hC0 | (8'(te) << 3) | 8'(n);
    wr(1'b0, base);
    wr(1'b1, 8'h00);
    ext_in = !te;
    idle(4);
    wr(1'b0, base | 8'h10);
    idle(2);
    ext_in = te;
    idle(w);
    ext_in = !te;
    idle(6);
    rd(1'b1, v);
    chk($sformatf("R8 width te=%0d n=%0d w=%0d", te, n, w), v, w >> n);
    rd(1'b0, v);
    chk("R9 run cleared after measurement", v[4], 1'b0);
    ext_in = te;
    idle(3);
    ext_in = !te;
    idle(6);
    rd(1'b1, v);
    chk("R9 count holds after measurement", v, w >> n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish within 200000 cycles");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    rd(1'b0, v); chk("R10 reset control", v, 8'h00);
    rd(1'b1, v); chk("R10 reset count", v, 8'h00);
    chk("R1 reset irq", irq, 1'b0);

    // R2: stopped write loads count
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R2 stopped load", v, 8'h5A);

    // R10: spare bit reads zero
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk("R10 spare bit", v, 8'hDF);
    wr(1'b0, 8'h00);

    // R6: timer divider sweep
    for (int n = 0; n < 8; n++) begin
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h90 | 8'(n));
      idle((1 << n) - 1);
      rd(1'b1, v); chk($sformatf("R6 before first tick n=%0d", n), v, 8'd0);
      idle(1);
      rd(1'b1, v); chk($sformatf("R6 first tick n=%0d", n), v, 8'd1);
      idle(2 * (1 << n) - 1);
      rd(1'b1, v); chk($sformatf("R6 third period end n=%0d", n), v, 8'd2);
      idle(1);
      rd(1'b1, v); chk($sformatf("R6 third tick n=%0d", n), v, 8'd3);
    end

    // R5: stop holds the count
    wr(1'b0, 8'h87);
    rd(1'b1, v);
    idle(300);
    rd(1'b1, v2); chk("R5 stopped count holds", v2, v);

    // R1: wrap with reload FD at 1:1
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hFD);
    wr(1'b0, 8'h90);
    for (int m = 0; m < 10; m++) begin
      rd(1'b1, v);
      chk($sformatf("R1 count m=%0d", m), v, 8'hFD + 8'(m % 3));
      chk($sformatf("R1 irq m=%0d", m), irq, (m > 0) && (m % 3 == 0));
      idle(1);
    end

    // R3: running write defers to next wrap
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'h90);
    wr(1'b1, 8'h40);
    rd(1'b1, v); chk("R3 running write ignored", v, 8'hF1);
    idle(14);
    rd(1'b1, v); chk("R3 before wrap", v, 8'hFF);
    chk("R3 no irq before wrap", irq, 1'b0);
    idle(1);
    rd(1'b1, v); chk("R3 new reload at wrap", v, 8'h40);
    chk("R1 irq at wrap", irq, 1'b1);
    idle(1);
    rd(1'b1, v); chk("R3 after wrap", v, 8'h41);
    chk("R1 irq single cycle", irq, 1'b0);

    // R4: idle mode with run set
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h33);
    wr(1'b0, 8'h10);
    idle(20);
    rd(1'b1, v); chk("R4 idle mode holds", v, 8'h33);
    wr(1'b1, 8'h44);
    rd(1'b1, v); chk("R2 idle mode write loads", v, 8'h44);

    // R7: event counting, rising edges, divider at max
    wr(1'b0, 8'h40);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h57);
    ext_in = 1'b1;
    idle(2);
    rd(1'b1, v); chk("R7 latency before", v, 8'h10);
    idle(1);
    rd(1'b1, v); chk("R7 latency third edge", v, 8'h11);
    ext_in = 1'b0;
    idle(3);
    rd(1'b1, v); chk("R7 falling not counted", v, 8'h11);
    for (int p = 0; p < 4; p++) begin
      ext_in = 1'b1; idle(3);
      ext_in = 1'b0; idle(3);
    end
    rd(1'b1, v); chk("R7 rising count", v, 8'h15);

    // R7: falling edges
    wr(1'b0, 8'h47);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h5F);
    for (int p = 0; p < 3; p++) begin
      ext_in = 1'b1; idle(3);
      ext_in = 1'b0; idle(3);
    end
    rd(1'b1, v); chk("R7 falling count", v, 8'h23);
    ext_in = 1'b1; idle(4);
    rd(1'b1, v); chk("R7 rising ignored", v, 8'h23);
    ext_in = 1'b0; idle(4);
    rd(1'b1, v); chk("R7 falling counted", v, 8'h24);

    // R8, R9: pulse width measurement
    wr(1'b0, 8'h00);
    measure(1'b1, 0, 1);
    measure(1'b1, 0, 5);
    measure(1'b1, 0, 17);
    measure(1'b0, 0, 4);
    measure(1'b0, 0, 9);
    measure(1'b1, 1, 8);
    measure(1'b0, 2, 12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule